// File: doc/BRIEF.md
# DDR SDRAM Command Decoder

This block watches the command and address bus of one four-bank DDR SDRAM rank and works out, on every rising clock edge, what the rank has been told to do. It decodes the chip select, row strobe, column strobe and write enable lines into a command code. It keeps an open or closed state for every bank, together with the row held open in each. It also keeps a copy of the burst settings loaded by a mode register set command.

It models the two meanings of address bit 10. On a read or write, bit 10 closes the bank by itself once the burst is over. On a precharge, bit 10 closes every bank. The block raises a one-cycle flag for three kinds of fault: a column access to a closed bank, an activate to a bank that is already open, and a command issued too soon after a mode register set. It also shows which bytes each accepted write may store. A monitor or a controller self-check can use it to follow the rank's state cycle by cycle. Every output is registered and reflects the command sampled at the preceding rising edge.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: Inputs are sampled only at the rising edge. After that edge `cmd_o` shows the decoded command, coded 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode set. The decode uses {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set. Every other code decodes as a no-op.
- R2: When cs_n is high or cke is low at an edge, the command decodes as a no-op and changes no bank or mode state. Automatic closes already counting down still complete.
- R3: An activate to a closed bank `ba` opens it and records addr[12:0] as its open row.
- R4: A read or write to an open bank with addr[10]=1 closes that bank exactly burst_len/2 edges after the command edge. With addr[10]=0 the bank stays open.
- R5: A precharge with addr[10]=1 closes all four banks whatever `ba` is. With addr[10]=0 it closes only bank `ba`. Precharging a closed bank is not a fault.
- R6: A read or write to a closed bank pulses `err_idle_o` for one cycle. An activate to an open bank pulses `err_open_o` for one cycle. In both cases the bank states and open rows are left unchanged.
- R7: After an accepted write, `wr_byte_en_o` equals the bitwise inverse of `dm`: a high mask bit blocks its byte. After any other command, including a read, it is all zeros.
- R8: After an accepted mode set, any command other than a no-op in the next MRS_GAP-1 edges pulses `err_mrs_o`. That command is dropped and changes no state. Faults from this rule take precedence over R6.
- R9: A mode set with ba=0 loads the burst length from addr[2:0] (001→2, 010→4, 011→8, other codes keep the old value), interleaved order from addr[3], and CAS latency in half cycles from addr[6:4] (010→4, 110→5, other codes keep the old value). A mode set with ba≠0 leaves the mode unchanged.
- R10: After reset all banks are closed, `cmd_o` is 0, all fault flags and byte enables are 0, the burst length is 2, the order is sequential and the CAS latency is 5 half cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low forces a no-op |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column and mode field address |
| dm | input | 8 | Write byte masks, high blocks a byte |
| cmd_o | output | 3 | Decoded command code |
| bank_active_o | output | 4 | One bit per bank, high when open |
| open_row_o | output | 52 | Open row per bank, bank b at bits [13b+12:13b] |
| err_idle_o | output | 1 | Column access to a closed bank |
| err_open_o | output | 1 | Activate to an open bank |
| err_mrs_o | output | 1 | Command inside the mode set gap |
| wr_byte_en_o | output | 8 | Byte enables of the last accepted write |
| burst_len_o | output | 4 | Burst length in beats |
| interleave_o | output | 1 | High for interleaved burst order |
| cas_half_o | output | 3 | CAS latency in half clock cycles |

## Verification
The hardest case to reach is a collision at the very edge where an automatic close falls due. A new read with bit 10 set must then restart the countdown and keep the bank open. An activate at that same edge must still see the bank as open and be flagged. Random stimulus weighted toward activates and column commands on only four banks, with the burst length changed now and then by mode sets, lands on these edges often. A bench model that applies the countdown first and the new command second predicts every one of them. Directed sequences also place a command straight after a mode set, and a masked write followed by a read.

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder #(
  parameter int NBANK   = 4,
  parameter int ROW_W   = 13,
  parameter int DM_W    = 8,
  parameter int MRS_GAP = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke,
  input  logic                     cs_n,
  input  logic                     ras_n,
  input  logic                     cas_n,
  input  logic                     we_n,
  input  logic [$clog2(NBANK)-1:0] ba,
  input  logic [ROW_W-1:0]         addr,
  input  logic [DM_W-1:0]          dm,
  output logic [2:0]               cmd_o,
  output logic [NBANK-1:0]         bank_active_o,
  output logic [NBANK*ROW_W-1:0]   open_row_o,
  output logic                     err_idle_o,
  output logic                     err_open_o,
  output logic                     err_mrs_o,
  output logic [DM_W-1:0]          wr_byte_en_o,
  output logic [3:0]               burst_len_o,
  output logic                     interleave_o,
  output logic [2:0]               cas_half_o
);
  localparam int CNT_W = 4;
  localparam int GAP_W = $clog2(MRS_GAP) + 1;
  localparam int AP_BIT = 10;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6;

  logic [2:0]       cmd;
  logic [ROW_W-1:0] row_q [NBANK];
  logic [CNT_W-1:0] apc_q [NBANK];
  logic [GAP_W-1:0] gap_q;
  logic             gap_hit, bank_hit, ap;

  always_comb begin
    cmd = C_NOP;
    if (cke && !cs_n)
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_MRS;
        default: cmd = C_NOP;
      endcase
  end

  assign gap_hit  = (gap_q != '0) && (cmd != C_NOP);
  assign bank_hit = bank_active_o[ba];
  assign ap       = addr[AP_BIT];

  for (genvar g = 0; g < NBANK; g++) begin : g_row
    assign open_row_o[g*ROW_W +: ROW_W] = row_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o         <= C_NOP;
      bank_active_o <= '0;
      err_idle_o    <= 1'b0;
      err_open_o    <= 1'b0;
      err_mrs_o     <= 1'b0;
      wr_byte_en_o  <= '0;
      burst_len_o   <= 4'd2;
      interleave_o  <= 1'b0;
      cas_half_o    <= 3'd5;
      gap_q         <= '0;
      for (int b = 0; b < NBANK; b++) begin
        row_q[b] <= '0;
        apc_q[b] <= '0;
      end
    end else begin
      cmd_o        <= cmd;
      err_idle_o   <= 1'b0;
      err_open_o   <= 1'b0;
      err_mrs_o    <= 1'b0;
      wr_byte_en_o <= '0;
      gap_q        <= (gap_q != '0) ? gap_q - GAP_W'(1) : '0;
      for (int b = 0; b < NBANK; b++)
        if (apc_q[b] != '0) begin
          apc_q[b] <= apc_q[b] - CNT_W'(1);
          if (apc_q[b] == CNT_W'(1)) bank_active_o[b] <= 1'b0;
        end
      if (gap_hit) err_mrs_o <= 1'b1;
      else
        case (cmd)
          C_ACT:
            if (bank_hit) err_open_o <= 1'b1;
            else begin
              bank_active_o[ba] <= 1'b1;
              row_q[ba]         <= addr;
            end
          C_RD, C_WR:
            if (!bank_hit) err_idle_o <= 1'b1;
            else begin
              if (ap) begin
                apc_q[ba]         <= burst_len_o >> 1;
                bank_active_o[ba] <= 1'b1;
              end
              if (cmd == C_WR) wr_byte_en_o <= ~dm;
            end
          C_PRE:
            if (ap) begin
              bank_active_o <= '0;
              for (int b = 0; b < NBANK; b++) apc_q[b] <= '0;
            end else begin
              bank_active_o[ba] <= 1'b0;
              apc_q[ba]         <= '0;
            end
          C_MRS: begin
            gap_q <= GAP_W'(MRS_GAP - 1);
            if (ba == '0) begin
              case (addr[2:0])
                3'b001:  burst_len_o <= 4'd2;
                3'b010:  burst_len_o <= 4'd4;
                3'b011:  burst_len_o <= 4'd8;
                default: ;
              endcase
              interleave_o <= addr[3];
              case (addr[6:4])
                3'b010:  cas_half_o <= 3'd4;
                3'b110:  cas_half_o <= 3'd5;
                default: ;
              endcase
            end
          end
          default: ;
        endcase
    end
  end

  p_deselect_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke || cs_n) |=> (cmd_o == C_NOP));
  p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT && gap_q == '0 && !bank_hit) |=>
      (bank_active_o[$past(ba)] && row_q[$past(ba)] == $past(addr)));
  p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE && gap_q == '0 && ap) |=> (bank_active_o == '0));
  p_err_keeps_rows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_open_o || err_idle_o) |-> $stable(open_row_o));
  p_one_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_idle_o, err_open_o, err_mrs_o}));
  p_read_no_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD) |=> (wr_byte_en_o == '0));
  p_mrs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == C_MRS && !err_mrs_o && cmd != C_NOP) |=> err_mrs_o);
endmodule

// File: tb/test_ddr_cmd_decoder.sv
`timescale 1ns/1ps
module test_ddr_cmd_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic [7:0] dm = '0;
  logic [2:0] cmd_o;
  logic [3:0] bank_active_o;
  logic [51:0] open_row_o;
  logic err_idle_o, err_open_o, err_mrs_o;
  logic [7:0] wr_byte_en_o;
  logic [3:0] burst_len_o;
  logic interleave_o;
  logic [2:0] cas_half_o;

  int total = 0, bad = 0;
  bit m_act[4];
  logic [12:0] m_row[4];
  int m_apc[4];
  int m_gap, m_bl, m_cl;
  bit m_il;
  int e_cmd;
  bit e_ei, e_eo, e_em;
  logic [7:0] e_we;

  always #4 clk = ~clk;

  ddr_cmd_decoder i_ddr_cmd_decoder (
    .clk, .rst_n, .cke, .cs_n, .ras_n, .cas_n, .we_n, .ba, .addr, .dm,
    .cmd_o, .bank_active_o, .open_row_o, .err_idle_o, .err_open_o, .err_mrs_o,
    .wr_byte_en_o, .burst_len_o, .interleave_o, .cas_half_o);

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int decode(bit k, bit c, logic [2:0] code);
    if (!k || c) return 0;
    case (code)
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return 4;
      3'b001: return 5;
      3'b000: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    bit n_act[4];
    int n_apc[4];
    int c = decode(cke, cs_n, {ras_n, cas_n, we_n});
    int b = ba;
    for (int i = 0; i < 4; i++) begin
      n_act[i] = m_act[i];
      n_apc[i] = m_apc[i];
      if (m_apc[i] != 0) begin
        n_apc[i] = m_apc[i] - 1;
        if (m_apc[i] == 1) n_act[i] = 0;
      end
    end
    e_cmd = c; e_ei = 0; e_eo = 0; e_em = 0; e_we = '0;
    if (m_gap != 0 && c != 0) e_em = 1;
    else case (c)
      1: if (m_act[b]) e_eo = 1; else begin n_act[b] = 1; m_row[b] = addr; end
      2, 3: if (!m_act[b]) e_ei = 1;
            else begin
              if (addr[10]) begin n_apc[b] = m_bl / 2; n_act[b] = 1; end
              if (c == 3) e_we = ~dm;
            end
      4: if (addr[10]) for (int i = 0; i < 4; i++) begin n_act[i] = 0; n_apc[i] = 0; end
         else begin n_act[b] = 0; n_apc[b] = 0; end
      default: ;
    endcase
    m_gap = (m_gap != 0) ? m_gap - 1 : 0;
    if (c == 6 && !e_em) begin
      m_gap = 1;
      if (b == 0) begin
        if (addr[2:0] == 1) m_bl = 2;
        if (addr[2:0] == 2) m_bl = 4;
        if (addr[2:0] == 3) m_bl = 8;
        m_il = addr[3];
        if (addr[6:4] == 3'b010) m_cl = 4;
        if (addr[6:4] == 3'b110) m_cl = 5;
      end
    end
    for (int i = 0; i < 4; i++) begin m_act[i] = n_act[i]; m_apc[i] = n_apc[i]; end
  endtask

  task automatic compare(bit valid);
    logic [3:0] ea;
    for (int i = 0; i < 4; i++) ea[i] = m_act[i];
    chk(cmd_o == 3'(e_cmd), valid ? "R1" : "R2", "cmd", cmd_o, e_cmd);
    chk(bank_active_o == ea, "R3/R4/R5", "bank_active", bank_active_o, ea);
    for (int i = 0; i < 4; i++)
      if (m_act[i]) chk(open_row_o[i*13 +: 13] == m_row[i], "R3", "open_row", open_row_o[i*13 +: 13], m_row[i]);
    chk({err_idle_o, err_open_o} == {e_ei, e_eo}, "R6", "err_idle/err_open", {err_idle_o, err_open_o}, {e_ei, e_eo});
    chk(err_mrs_o == e_em, "R8", "err_mrs", err_mrs_o, e_em);
    chk(wr_byte_en_o == e_we, "R7", "wr_byte_en", wr_byte_en_o, e_we);
    chk({burst_len_o, interleave_o, cas_half_o} == {4'(m_bl), m_il, 3'(m_cl)}, "R9", "mode",
        {burst_len_o, interleave_o, cas_half_o}, {4'(m_bl), m_il, 3'(m_cl)});
  endtask

  task automatic cyc(bit k, bit c, logic [2:0] code, logic [1:0] b, logic [12:0] a, logic [7:0] m);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = code; ba = b; addr = a; dm = m;
    model_step();
    @(negedge clk);
    compare(k && !c);
  endtask

  localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100, K_PRE = 3'b010,
                         K_REF = 3'b001, K_MRS = 3'b000, K_NOP = 3'b111;

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", "timeout", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_row[i] = '0; m_apc[i] = 0; end
    m_gap = 0; m_bl = 2; m_cl = 5; m_il = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk(cmd_o == 0 && bank_active_o == 0, "R10", "reset cmd/banks", {cmd_o, bank_active_o}, 0);
    chk({err_idle_o, err_open_o, err_mrs_o, wr_byte_en_o} == 0, "R10", "reset flags", {err_idle_o, err_open_o, err_mrs_o, wr_byte_en_o}, 0);
    chk({burst_len_o, interleave_o, cas_half_o} == {4'd2, 1'b0, 3'd5}, "R10", "reset mode", {burst_len_o, interleave_o, cas_half_o}, {4'd2, 1'b0, 3'd5});
    // R2 deselect and clock-enable low
    cyc(1, 1, K_ACT, 0, 13'h0123, 0);
    cyc(0, 0, K_ACT, 0, 13'h0123, 0);
    // R3 R4 auto close with burst of 2
    cyc(1, 0, K_ACT, 1, 13'h1abc, 0);
    cyc(1, 0, K_RD, 1, 13'h0400, 0);
    cyc(1, 0, K_NOP, 0, 0, 0);
    // R8 R9 mode set then an early command
    cyc(1, 0, K_MRS, 0, 13'h006b, 0);
    cyc(1, 0, K_ACT, 2, 13'h0555, 0);
    cyc(1, 0, K_NOP, 0, 0, 0);
    // R7 masked write then read, R4 close after 4 edges
    cyc(1, 0, K_ACT, 2, 13'h0777, 0);
    cyc(1, 0, K_WR, 2, 13'h0410, 8'ha5);
    cyc(1, 0, K_RD, 2, 13'h0010, 8'hff);
    for (int i = 0; i < 4; i++) cyc(1, 0, K_NOP, 0, 0, 0);
    // R6 faults
    cyc(1, 0, K_RD, 3, 0, 0);
    cyc(1, 0, K_ACT, 0, 13'h0042, 0);
    cyc(1, 0, K_ACT, 0, 13'h0099, 0);
    // R5 precharge all and single
    cyc(1, 0, K_ACT, 3, 13'h0011, 0);
    cyc(1, 0, K_PRE, 1, 13'h0000, 0);
    cyc(1, 0, K_PRE, 2, 13'h0400, 0);
    cyc(1, 0, K_REF, 0, 0, 0);
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom % 16;
      logic [2:0] code;
      logic [12:0] a = 13'($urandom);
      bit k = ($urandom % 12) != 0;
      bit c = ($urandom % 10) == 0;
      case (r)
        0, 1, 2, 3: code = K_ACT;
        4, 5, 6:    code = K_RD;
        7, 8:       code = K_WR;
        9, 10:      code = K_PRE;
        11:         code = K_REF;
        12:         code = (($urandom % 3) == 0) ? K_MRS : K_NOP;
        14:         code = 3'b110;
        default:    code = K_NOP;
      endcase
      if (code == K_MRS && ($urandom % 2) == 0) a[6:4] = (($urandom % 2) == 0) ? 3'b010 : 3'b110;
      cyc(k, c, code, 2'($urandom), a, 8'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule